// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device-side manager for one receive ring of buffer descriptors kept in host memory. Software hands empty buffers to the device by advancing a driver write index in steps of eight. As frames arrive, the controller takes descriptors in ring order, packs frames into the buffer it currently holds open, and closes that buffer once a programmed quiet time has passed. On every close it advances its read index, makes that index readable as the completion word, and can raise an interrupt toward the host.

Software controls the block through a small register bus with four word locations: 0 holds the configuration, 1 the driver write index, 2 the channel status and 3 the completion word. The configuration carries a channel mode, the ring size as a power-of-two exponent, a buffer size code, an interrupt destination and a close timeout. The channel can run normally, pause once the current buffer has timed out, or stop at once, which closes the open buffer as soon as the frame in flight ends. Fetching descriptors and moving payload are outside this block. A one-cycle take pulse with the descriptor index stands in for both.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset the configuration, the write index, the read index and the completion word all read 0. Status bit 24 (idle) reads 1. The take and interrupt outputs are low.
- R2: Configuration bits 23:20 hold the ring exponent N. Values below 5 act as 5 and values above 12 act as 12, while the raw value reads back unchanged. Indices wrap at 2^N, so after entry 2^N-1 the next index is 0.
- R3: A write to location 1 is ignored when its low three bits are not all zero. An accepted value is stored masked to the current ring size.
- R4: A frame start is accepted only in mode 10 (bits 31:30) and only when no frame is in progress. If no buffer is open, accepting it takes the descriptor at the read index: `desc_take_o` is high for the one cycle after the sampling edge, with `desc_idx_o` equal to that index.
- R5: When the read index equals the write index and no buffer is open, a frame start is dropped and no descriptor is taken.
- R6: An open buffer with no frame in progress closes after timeout × 32 microsecond ticks of frame inactivity. The timeout is bits 11:4, and one tick is TICK_DIV clocks. A timeout of 0 closes the buffer on the cycle after the frame end. On close the read index advances, and location 3 returns it in bits 11:0.
- R7: A frame that starts while a buffer is open shares that buffer and takes no new descriptor. Each accepted frame start and each frame end restarts the timeout.
- R8: `irq_o` pulses for one cycle on each close only when bits 13:12 equal 01. Any other code gives no interrupt.
- R9: Mode 01 refuses new frames, and an open buffer still closes by timeout. Mode 00 (and 11) refuses new frames and closes the open buffer as soon as no frame is in progress, without waiting for the timeout.
- R10: Location 2 bit 24 reads 1 exactly when the mode is not 10, no frame is in progress and no buffer is open. All other bits of location 2 read 0.
- R11: The configuration reads back bits 31:30, 23:20, 17:16 (buffer size code 00 to 11 for 4K to 16K), 13:12 and 11:4 as written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word location: 0 config, 1 write index, 2 status, 3 completion |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| frm_start_i | input | 1 | Frame arrival pulse |
| frm_end_i | input | 1 | Frame end pulse |
| desc_take_o | output | 1 | One-cycle pulse: a descriptor was taken |
| desc_idx_o | output | 12 | Index of the descriptor taken |
| irq_o | output | 1 | One-cycle interrupt pulse on buffer close |

## Verification
Assertions check on every cycle that a take happens only in run mode, only with room in the ring and never while a buffer is open. They also check that an interrupt pulse only follows a host destination code, that the read index moves only on a close, that the stored write index stays a multiple of eight, and that the timeout counter never goes backwards between restarts. Only the bench scenarios can show the actual descriptor order across a ring wrap, the exponent clamping seen through masked write indices, and the close time set by the timeout, including the restart when a second frame shares a buffer. The same applies to the different ways the two pause modes finish the open buffer.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [1:0] {
      CH_OFF       = 2'b00,
      CH_PAUSE_EOF = 2'b01,
      CH_RUN       = 2'b10,
      CH_RSVD      = 2'b11
   } ch_mode_e;

   typedef struct packed {
      ch_mode_e    mode;
      logic [3:0]  ring_log;
      logic [1:0]  buf_sz;
      logic [1:0]  irq_dst;
      logic [7:0]  tmo;
   } rxr_cfg_t;

   localparam logic [1:0] A_CFG  = 2'd0;
   localparam logic [1:0] A_WIDX = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
   localparam logic [1:0] A_DONE = 2'd3;

   localparam int IDLE_BIT = 24;
   localparam logic [1:0] DST_HOST = 2'b01;

endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
   import rxr_pkg::*;
#(
   parameter int IDX_W   = 12,
   parameter int MIN_LOG = 5,
   parameter int MAX_LOG = 12,
   parameter int STEP    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [31:0]      wdata,
   input  logic             idle,
   input  logic [IDX_W-1:0] rd_idx,
   output rxr_cfg_t         cfg,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] ring_mask,
   output logic [31:0]      rdata
);
   localparam int STEP_BITS = $clog2(STEP);

   if (MAX_LOG > IDX_W) begin : g_bad_max
      $error("MAX_LOG exceeds index width");
   end
   if (MIN_LOG > MAX_LOG) begin : g_bad_min
      $error("MIN_LOG above MAX_LOG");
   end
   if ((1 << STEP_BITS) != STEP) begin : g_bad_step
      $error("STEP must be a power of two");
   end

   logic [3:0]     eff_log;
   logic [IDX_W:0] mask_full;

   always_comb begin
      if (cfg.ring_log < 4'(MIN_LOG))      eff_log = 4'(MIN_LOG);
      else if (cfg.ring_log > 4'(MAX_LOG)) eff_log = 4'(MAX_LOG);
      else                                 eff_log = cfg.ring_log;
      mask_full = ({{IDX_W{1'b0}}, 1'b1} << eff_log) - 1'b1;
      ring_mask = mask_full[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         wr_idx <= '0;
      end else if (wr_en) begin
         if (addr == A_CFG) begin
            cfg.mode     <= ch_mode_e'(wdata[31:30]);
            cfg.ring_log <= wdata[23:20];
            cfg.buf_sz   <= wdata[17:16];
            cfg.irq_dst  <= wdata[13:12];
            cfg.tmo      <= wdata[11:4];
         end else if (addr == A_WIDX && wdata[STEP_BITS-1:0] == '0) begin
            wr_idx <= wdata[IDX_W-1:0] & ring_mask;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CFG: begin
            rdata[31:30] = cfg.mode;
            rdata[23:20] = cfg.ring_log;
            rdata[17:16] = cfg.buf_sz;
            rdata[13:12] = cfg.irq_dst;
            rdata[11:4]  = cfg.tmo;
         end
         A_WIDX: rdata[IDX_W-1:0] = wr_idx;
         A_STAT: rdata[IDLE_BIT]  = idle;
         default: rdata[IDX_W-1:0] = rd_idx;
      endcase
   end

   AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idx[STEP_BITS-1:0] == '0); // R3

endmodule

// File: rtl/rxr_close_timer.sv
module rxr_close_timer #(
   parameter int TICK_DIV = 50,
   parameter int TMO_W    = 8,
   parameter int UNIT_LOG = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [TMO_W-1:0] tmo,
   output logic             expired
);
   localparam int CNT_W = TMO_W + UNIT_LOG;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   logic             tick;
   logic [CNT_W-1:0] us_cnt;

   if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_div
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         pre <= '0;
         else if (restart)                   pre <= '0;
         else if (pre == PRE_W'(TICK_DIV-1)) pre <= '0;
         else                                pre <= pre + 1'b1;
      end
      assign tick = (pre == PRE_W'(TICK_DIV-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     us_cnt <= '0;
      else if (restart)               us_cnt <= '0;
      else if (tick && !(&us_cnt))    us_cnt <= us_cnt + 1'b1;
   end

   assign expired = us_cnt >= {tmo, {UNIT_LOG{1'b0}}};

   AST_TMR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> us_cnt >= $past(us_cnt)); // R6

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close,
   input  logic [IDX_W-1:0] ring_mask,
   input  logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic             room
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_idx <= '0;
      else if (close) rd_idx <= (rd_idx + 1'b1) & ring_mask;
   end

   assign room = (rd_idx != wr_idx);

   AST_RD_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      !close |=> $stable(rd_idx)); // R6

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
   import rxr_pkg::*;
#(
   parameter int IDX_W    = 12,
   parameter int MIN_LOG  = 5,
   parameter int MAX_LOG  = 12,
   parameter int STEP     = 8,
   parameter int TICK_DIV = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [31:0]      reg_wdata_i,
   output logic [31:0]      reg_rdata_o,
   input  logic             frm_start_i,
   input  logic             frm_end_i,
   output logic             desc_take_o,
   output logic [IDX_W-1:0] desc_idx_o,
   output logic             irq_o
);
   rxr_cfg_t         cfg;
   logic [IDX_W-1:0] wr_idx, rd_idx, ring_mask;
   logic             room, expired;
   logic             in_frame, buf_open;
   logic             accept_start, take, close, restart, stop_now, idle;

   assign stop_now     = (cfg.mode == CH_OFF) || (cfg.mode == CH_RSVD);
   assign accept_start = frm_start_i && !in_frame && (cfg.mode == CH_RUN)
                         && (buf_open || room);
   assign take         = accept_start && !buf_open;
   assign close        = buf_open && !in_frame && !accept_start
                         && (stop_now || expired);
   assign restart      = accept_start || (frm_end_i && in_frame);
   assign idle         = (cfg.mode != CH_RUN) && !in_frame && !buf_open;

   rxr_cfg_regs #(
      .IDX_W(IDX_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .STEP(STEP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
      .wdata(reg_wdata_i), .idle(idle), .rd_idx(rd_idx), .cfg(cfg),
      .wr_idx(wr_idx), .ring_mask(ring_mask), .rdata(reg_rdata_o)
   );

   rxr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .close(close), .ring_mask(ring_mask),
      .wr_idx(wr_idx), .rd_idx(rd_idx), .room(room)
   );

   rxr_close_timer #(.TICK_DIV(TICK_DIV), .TMO_W(8), .UNIT_LOG(5)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tmo(cfg.tmo),
      .expired(expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame    <= 1'b0;
         buf_open    <= 1'b0;
         desc_take_o <= 1'b0;
         desc_idx_o  <= '0;
         irq_o       <= 1'b0;
      end else begin
         desc_take_o <= take;
         irq_o       <= close && (cfg.irq_dst == DST_HOST);
         if (take) desc_idx_o <= rd_idx;
         if (accept_start)                in_frame <= 1'b1;
         else if (frm_end_i && in_frame)  in_frame <= 1'b0;
         if (take)       buf_open <= 1'b1;
         else if (close) buf_open <= 1'b0;
      end
   end

   AST_TAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      desc_take_o |-> $past(cfg.mode) == CH_RUN); // R4
   AST_TAKE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      desc_take_o |-> $past(rd_idx) != $past(wr_idx)); // R5
   AST_NO_TAKE_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      desc_take_o |-> !$past(buf_open)); // R7
   AST_IRQ_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(cfg.irq_dst) == DST_HOST); // R8

endmodule

// File: tb/rx_ring_ctrl_tb_top.sv
module rx_ring_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        frm_start_i = 1'b0;
   logic        frm_end_i = 1'b0;
   logic        desc_take_o;
   logic [11:0] desc_idx_o;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   int take_cnt = 0;
   int irq_cnt = 0;
   logic [11:0] exp_q[$];

   always #10 clk = ~clk;

   rx_ring_ctrl #(.TICK_DIV(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .frm_start_i(frm_start_i), .frm_end_i(frm_end_i),
      .desc_take_o(desc_take_o), .desc_idx_o(desc_idx_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares each taken descriptor index with the queue
   always @(negedge clk) begin
      if (rst_n && desc_take_o) begin
         take_cnt++;
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R4 actual=%h expected=none (unexpected take)", desc_idx_o);
         end else begin
            logic [11:0] e;
            e = exp_q.pop_front();
            if (desc_idx_o !== e) begin
               failures++;
               $display("FAIL R4 actual=%h expected=%h", desc_idx_o, e);
            end
         end
      end
      if (rst_n && irq_o) irq_cnt++;
   end

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr_i = a;
      #1 d = reg_rdata_o;
   endtask

   task automatic pulse_start(input bit expect_take, input logic [11:0] idx);
      if (expect_take) exp_q.push_back(idx);
      @(negedge clk); frm_start_i = 1'b1;
      @(negedge clk); frm_start_i = 1'b0;
   endtask

   task automatic pulse_end();
      @(negedge clk); frm_end_i = 1'b1;
      @(negedge clk); frm_end_i = 1'b0;
   endtask

   task automatic send_frame(input bit expect_take, input logic [11:0] idx);
      pulse_start(expect_take, idx);
      repeat (2) @(negedge clk);
      pulse_end();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R4 actual=%0d expected=0 (takes still pending)", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      chk("R1 take low", {31'b0, desc_take_o}, 32'h0);
      chk("R1 irq low", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;
      reg_read(2'd0, d); chk("R1 config", d, 32'h0);
      reg_read(2'd1, d); chk("R1 write index", d, 32'h0);
      reg_read(2'd3, d); chk("R1 completion", d, 32'h0);
      reg_read(2'd2, d); chk("R1 R10 idle after reset", d, 32'h0100_0000);

      // run, exponent 5, 8K, host irq, timeout 0, stray bit 0
      reg_write(2'd0, 32'h8051_1001);
      reg_read(2'd0, d); chk("R11 config readback", d, 32'h8051_1000);
      reg_read(2'd2, d); chk("R10 running not idle", d, 32'h0);

      send_frame(1'b0, 12'd0);
      chk("R5 no take on empty ring", take_cnt, 0);

      reg_write(2'd1, 32'd5);
      reg_read(2'd1, d); chk("R3 unaligned write ignored", d, 32'd0);
      reg_write(2'd1, 32'd8);
      reg_read(2'd1, d); chk("R3 aligned write taken", d, 32'd8);

      for (int i = 0; i < 8; i++) send_frame(1'b1, 12'(i));
      reg_read(2'd3, d); chk("R6 completion after 8", d, 32'd8);
      chk("R8 irq per close", irq_cnt, 8);
      send_frame(1'b0, 12'd0);
      chk("R5 full ring drops frame", take_cnt, 8);

      reg_write(2'd1, 32'd0);
      for (int i = 8; i < 32; i++) send_frame(1'b1, 12'(i));
      reg_read(2'd3, d); chk("R2 read index wraps to 0", d, 32'd0);
      send_frame(1'b0, 12'd0);
      chk("R5 drop after wrap", take_cnt, 32);

      reg_write(2'd0, 32'h80D1_1000);
      reg_write(2'd1, 32'd40);
      reg_read(2'd1, d); chk("R2 exponent 13 acts as 12", d, 32'd40);
      reg_write(2'd0, 32'h8031_1000);
      reg_write(2'd1, 32'd40);
      reg_read(2'd1, d); chk("R2 exponent 3 acts as 5", d, 32'd8);
      reg_read(2'd0, d); chk("R2 raw exponent reads back", d, 32'h8031_1000);

      // no interrupt destination
      reg_write(2'd0, 32'h8031_0000);
      send_frame(1'b1, 12'd0);
      reg_read(2'd3, d); chk("R6 close with timeout 0", d, 32'd1);
      chk("R8 no irq for destination 00", irq_cnt, 32);

      // timeout 1 = 32 ticks of 4 clocks
      reg_write(2'd0, 32'h8031_1010);
      send_frame(1'b1, 12'd1);
      repeat (90) @(negedge clk);
      reg_read(2'd3, d); chk("R6 not closed before timeout", d, 32'd1);
      send_frame(1'b0, 12'd0);
      repeat (100) @(negedge clk);
      reg_read(2'd3, d); chk("R7 timer restarted by shared frame", d, 32'd1);
      repeat (60) @(negedge clk);
      reg_read(2'd3, d); chk("R6 closed after timeout", d, 32'd2);
      chk("R7 shared frame took no descriptor", take_cnt, 34);
      chk("R8 irq on timeout close", irq_cnt, 33);

      // pause at end of frame
      pulse_start(1'b1, 12'd2);
      reg_write(2'd0, 32'h4031_1010);
      pulse_end();
      reg_read(2'd2, d); chk("R10 not idle with open buffer", d, 32'h0);
      send_frame(1'b0, 12'd0);
      repeat (160) @(negedge clk);
      reg_read(2'd3, d); chk("R9 pause-eof closes by timeout", d, 32'd3);
      reg_read(2'd2, d); chk("R10 idle after pause-eof", d, 32'h0100_0000);
      chk("R9 pause-eof refuses frames", take_cnt, 35);

      // immediate pause with long timeout
      reg_write(2'd0, 32'h8031_1FF0);
      pulse_start(1'b1, 12'd3);
      reg_write(2'd0, 32'h0031_1FF0);
      pulse_end();
      repeat (4) @(negedge clk);
      reg_read(2'd3, d); chk("R9 off closes at frame end", d, 32'd4);
      reg_read(2'd2, d); chk("R10 idle after off", d, 32'h0100_0000);
      send_frame(1'b0, 12'd0);
      chk("R9 off refuses frames", take_cnt, 36);
      chk("R8 irq count final", irq_cnt, 35);

      finish_run();
   end
endmodule